// File: doc/BRIEF.md
# Bus Request and Grant Handshake Controller

This block lets a processor core hand its external memory bus to an outside master. An active-low bus request is synchronized and, once the core has no external access in flight, the block switches off the core's address, data and strobe drivers, drives an active-low bus grant, and halts the core. When the request is withdrawn, grant is removed and the drivers are turned back on in the same cycle, and the core carries on from where it stopped.

A small external access engine runs the core's memory cycles. Each cycle lasts one more clock than its programmed wait-state count. An access that has started always finishes before the bus is handed over. An instruction that needs two accesses can lose the bus between its two halves, and the second half runs once the bus comes back. In go mode, a grant does not stop the core until the core actually needs the bus. An active-low hang output tells the current bus owner that the core is stalled waiting for the bus.

Top module: `busGrantCtl`

## Requirements
- R1: When the raw request `busReqN` goes low and no access is running, `busGrantN` goes low and `drvEn` goes low on the third rising clock edge after the input changed: two synchronizer edges and one decision edge.
- R2: With `goMode` low, `coreHalt` is high in every cycle in which `busGrantN` is low.
- R3: With `goMode` high, a grant alone leaves `coreHalt` low. `coreHalt` rises only while grant is held and the core has an external access waiting. `coreHalt` is never high while `busGrantN` is high.
- R4: An external access keeps `accessBusy` high for exactly `coreWaitStates`+1 cycles, for counts from 0 to 7. `accessDone` is high in the last of those cycles.
- R5: A request that arrives during an access leaves `busGrantN` high until the access ends. Grant goes low one cycle after the last busy cycle.
- R6: With `coreDouble` high, the bus may be granted between the two halves of the access. The second half, of the same length, starts only after the bus returns.
- R7: Three edges after `busReqN` returns high, `busGrantN` and `drvEn` both go high in the same cycle. A waiting access starts on the following edge.
- R8: Request and grant handling keeps working while `rstN` is low, so the bus can be granted while the core is held in reset.
- R9: `busHangN` goes low on the edge after the core asks for an external access while the bus is granted away. It returns high on the edge that ends the last busy cycle of that instruction's accesses.
- R10: While in reset with no request, `busGrantN`, `busHangN` and `drvEn` are high, and `coreHalt` and `accessBusy` are low.
- R11: No access starts while grant is held or while the synchronized request is asserted. A core request made during a grant produces no `accessBusy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the core-side logic |
| busReqN | input | 1 | Asynchronous active-low bus request from the outside master |
| goMode | input | 1 | High: let the core run while the bus is granted away |
| coreExtReq | input | 1 | Core wants an external access; held until `accessBusy` is seen |
| coreDouble | input | 1 | The requested access has two halves |
| coreWaitStates | input | 3 | Wait states per access half (0 to 7) |
| busGrantN | output | 1 | Active-low bus grant |
| drvEn | output | 1 | Enable for the address, data and strobe drivers |
| coreHalt | output | 1 | Stall for the core |
| busHangN | output | 1 | Active-low: core is stalled waiting for the bus |
| accessBusy | output | 1 | An external access cycle is in progress |
| accessDone | output | 1 | Last cycle of an access half |

## Verification
Grant and driver changes are due on the third edge after the raw request changes, so the bench drives inputs on a falling edge and samples after exactly three more falling edges. `coreHalt` follows grant and the core request in the same cycle. `busHangN` moves one edge after the blocked request or after the final busy cycle. A grant that follows an access is due one cycle after `accessBusy` falls. Access lengths are measured by counting falling-edge samples with `accessBusy` high. Every sample is taken half a period away from the active edge, at the cycle worked out for that result.

// File: rtl/busGrantPkg.sv
package busGrantPkg;
  localparam int WAIT_W = 3;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_BUSY,
    ACC_GAP
  } accState_t;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic countDown;
  } accStrobe_t;
endpackage

// File: rtl/busReqSync.sv
module busReqSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic reqNIn,
  output logic reqOut
);
  // No reset: the request path must keep working while the core is in reset.
  logic [STAGES-1:0] shiftQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) shiftQ <= ~reqNIn;
    end else begin : g_chain
      always_ff @(posedge clk) shiftQ <= {shiftQ[STAGES-2:0], ~reqNIn};
    end
  endgenerate

  assign reqOut = shiftQ[STAGES-1];
endmodule

// File: rtl/busAccessPath.sv
module busAccessPath
  import busGrantPkg::*;
#(
  parameter int WW = WAIT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  accStrobe_t    strobe,
  input  logic [WW-1:0] waitStates,
  output logic          lastCycle
);
  logic [WW-1:0] waitCnt;
  logic [WW-1:0] heldWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      heldWait <= '0;
    end else if (strobe.loadFirst) begin
      waitCnt  <= waitStates;
      heldWait <= waitStates;
    end else if (strobe.loadSecond) begin
      waitCnt <= heldWait;
    end else if (strobe.countDown && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign lastCycle = (waitCnt == '0);
endmodule

// File: rtl/busGrantCtrl.sv
module busGrantCtrl
  import busGrantPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncReq,
  input  logic       goMode,
  input  logic       coreExtReq,
  input  logic       coreDouble,
  input  logic       lastCycle,
  output accStrobe_t strobe,
  output logic       granted,
  output logic       hangFlag,
  output logic       coreHalt,
  output logic       accessBusy,
  output logic       accessDone
);
  accState_t state, nextState;
  logic secondLeft;
  logic startOk, wantAccess, finalDone;

  always_comb begin
    strobe     = '0;
    nextState  = state;
    startOk    = !granted && !syncReq;
    wantAccess = (state == ACC_IDLE && coreExtReq) || state == ACC_GAP;
    case (state)
      ACC_IDLE: if (coreExtReq && startOk) begin
        strobe.loadFirst = 1'b1;
        nextState        = ACC_BUSY;
      end
      ACC_BUSY: begin
        strobe.countDown = 1'b1;
        if (lastCycle) nextState = secondLeft ? ACC_GAP : ACC_IDLE;
      end
      ACC_GAP: if (startOk) begin
        strobe.loadSecond = 1'b1;
        nextState         = ACC_BUSY;
      end
      default: nextState = ACC_IDLE;
    endcase
  end

  assign finalDone = (state == ACC_BUSY) && lastCycle && !secondLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ACC_IDLE;
      secondLeft <= 1'b0;
      hangFlag   <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadFirst) secondLeft <= coreDouble;
      else if (state == ACC_BUSY && lastCycle) secondLeft <= 1'b0;
      if (finalDone) hangFlag <= 1'b0;
      else if (wantAccess && granted) hangFlag <= 1'b1;
    end
  end

  // Grant decision is outside the core reset so the bus can be lent during reset.
  always_ff @(posedge clk)
    granted <= syncReq && (granted || state != ACC_BUSY);

  assign coreHalt   = granted && (!goMode || wantAccess);
  assign accessBusy = (state == ACC_BUSY);
  assign accessDone = (state == ACC_BUSY) && lastCycle;
endmodule

// File: rtl/busGrantCtl.sv
module busGrantCtl
  import busGrantPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WW          = WAIT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReqN,
  input  logic          goMode,
  input  logic          coreExtReq,
  input  logic          coreDouble,
  input  logic [WW-1:0] coreWaitStates,
  output logic          busGrantN,
  output logic          drvEn,
  output logic          coreHalt,
  output logic          busHangN,
  output logic          accessBusy,
  output logic          accessDone
);
  logic       syncReq;
  logic       lastCycle;
  logic       granted;
  logic       hangFlag;
  accStrobe_t strobe;

  busReqSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .reqNIn(busReqN), .reqOut(syncReq)
  );

  busGrantCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .syncReq(syncReq), .goMode(goMode),
    .coreExtReq(coreExtReq), .coreDouble(coreDouble), .lastCycle(lastCycle),
    .strobe(strobe), .granted(granted), .hangFlag(hangFlag),
    .coreHalt(coreHalt), .accessBusy(accessBusy), .accessDone(accessDone)
  );

  busAccessPath #(.WW(WW)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .waitStates(coreWaitStates), .lastCycle(lastCycle)
  );

  assign busGrantN = !granted;
  assign drvEn     = !granted;
  assign busHangN  = !hangFlag;
endmodule

// File: rtl/busGrantChk.sv
module busGrantChk (
  input logic clk,
  input logic rstN,
  input logic syncReq,
  input logic goMode,
  input logic busGrantN,
  input logic coreHalt,
  input logic busHangN,
  input logic accessBusy
);
  AST_GRANT_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (syncReq && !accessBusy) |=> !busGrantN); // R1

  AST_HALT_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rstN)
    (!goMode && !busGrantN) |-> coreHalt); // R2

  AST_HALT_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    coreHalt |-> !busGrantN); // R3

  AST_BUSY_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    accessBusy |-> busGrantN); // R5

  AST_RELEASE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !syncReq |=> busGrantN); // R7

  AST_HANG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHangN) |-> $past(!busGrantN)); // R9

  AST_NO_START_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessBusy) |-> $past(busGrantN && !syncReq)); // R11
endmodule

bind busGrantCtl busGrantChk i_chk (
  .clk(clk), .rstN(rstN), .syncReq(syncReq), .goMode(goMode),
  .busGrantN(busGrantN), .coreHalt(coreHalt), .busHangN(busHangN),
  .accessBusy(accessBusy)
);

// File: tb/test_busGrantCtl.sv
module test_busGrantCtl;
  logic clk = 1'b0;
  logic rstN, busReqN, goMode, coreExtReq, coreDouble;
  logic [2:0] coreWaitStates;
  logic busGrantN, drvEn, coreHalt, busHangN, accessBusy, accessDone;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  busGrantCtl i_busGrantCtl (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .goMode(goMode),
    .coreExtReq(coreExtReq), .coreDouble(coreDouble),
    .coreWaitStates(coreWaitStates), .busGrantN(busGrantN), .drvEn(drvEn),
    .coreHalt(coreHalt), .busHangN(busHangN), .accessBusy(accessBusy),
    .accessDone(accessDone)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Fields: [9] busReqN [8] goMode [7] coreExtReq [6:4] hold cycles
  //         [3] busGrantN [2] coreHalt [1] busHangN [0] accessBusy
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_0_100_1_0_1_0,  // idle, no request
    10'b0_0_0_010_1_0_1_0,  // R1: still in synchronizer
    10'b0_0_0_001_0_1_1_0,  // R1, R2: granted, core halted
    10'b0_1_0_001_0_0_1_0,  // R3: go mode, no halt
    10'b0_1_1_001_0_1_0_0,  // R3, R9, R11: blocked access halts, hangs, no busy
    10'b1_1_1_010_0_1_0_0,  // R7: release still in synchronizer
    10'b1_1_1_001_1_0_0_0,  // R7: grant and drivers back
    10'b1_1_1_001_1_0_0_1,  // R7: waiting access starts next edge
    10'b1_1_0_001_1_0_1_0   // R9: hang clears after the access
  };

  task automatic countBusy(output int n);
    n = 0;
    for (int i = 0; i < 20 && accessBusy; i++) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    rstN = 1'b0; busReqN = 1'b1; goMode = 1'b0; coreExtReq = 1'b0;
    coreDouble = 1'b0; coreWaitStates = 3'd0;
    repeat (4) @(negedge clk);
    chk("R10 grantN", busGrantN, 1'b1);
    chk("R10 drvEn", drvEn, 1'b1);
    chk("R10 hangN", busHangN, 1'b1);
    chk("R10 halt", coreHalt, 1'b0);
    chk("R10 busy", accessBusy, 1'b0);
    busReqN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 grant in reset", busGrantN, 1'b0);
    chk("R8 drvEn in reset", drvEn, 1'b0);
    busReqN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 release in reset", busGrantN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      busReqN = VEC[v][9]; goMode = VEC[v][8]; coreExtReq = VEC[v][7];
      repeat (int'(VEC[v][6:4])) @(negedge clk);
      chk($sformatf("R1/R7 row%0d grantN", v), busGrantN, VEC[v][3]);
      chk($sformatf("R1/R7 row%0d drvEn", v), drvEn, VEC[v][3]);
      chk($sformatf("R2/R3 row%0d halt", v), coreHalt, VEC[v][2]);
      chk($sformatf("R9 row%0d hangN", v), busHangN, VEC[v][1]);
      chk($sformatf("R11 row%0d busy", v), accessBusy, VEC[v][0]);
    end
    goMode = 1'b0;
    @(negedge clk);

    // R4 with zero wait states, and R5 with a request during a long access
    coreWaitStates = 3'd0; coreExtReq = 1'b1;
    @(negedge clk);
    coreExtReq = 1'b0;
    chk("R4 accessDone ws0", accessDone, 1'b1);
    countBusy(n);
    chk("R4 length ws0", n == 1, 1'b1);

    coreWaitStates = 3'd5; coreExtReq = 1'b1;
    @(negedge clk);
    coreExtReq = 1'b0; busReqN = 1'b0;
    countBusy(n);
    chk("R4 length ws5", n == 6, 1'b1);
    chk("R5 grant deferred", busGrantN, 1'b1);
    @(negedge clk);
    chk("R5 grant after access", busGrantN, 1'b0);
    chk("R5 drivers off", drvEn, 1'b0);
    busReqN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 grant released", busGrantN, 1'b1);
    chk("R7 drivers on", drvEn, 1'b1);

    coreWaitStates = 3'd7; coreExtReq = 1'b1;
    @(negedge clk);
    coreExtReq = 1'b0;
    countBusy(n);
    chk("R4 length ws7", n == 8, 1'b1);

    // R6: double access with the bus lent between halves
    coreWaitStates = 3'd2; coreDouble = 1'b1; coreExtReq = 1'b1;
    @(negedge clk);
    coreExtReq = 1'b0; coreDouble = 1'b0; busReqN = 1'b0;
    countBusy(n);
    chk("R6 first half length", n == 3, 1'b1);
    chk("R6 no grant in gap yet", busGrantN, 1'b1);
    @(negedge clk);
    chk("R6 grant between halves", busGrantN, 1'b0);
    chk("R6 halted in gap", coreHalt, 1'b1);
    chk("R6 no busy while granted", accessBusy, 1'b0);
    @(negedge clk);
    chk("R9 hang in gap", busHangN, 1'b0);
    busReqN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 bus back", busGrantN, 1'b1);
    chk("R11 no start at release edge", accessBusy, 1'b0);
    @(negedge clk);
    chk("R6 second half starts", accessBusy, 1'b1);
    countBusy(n);
    chk("R6 second half length", n == 3, 1'b1);
    chk("R9 hang cleared", busHangN, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule